// File: doc/BRIEF.md
# Configuration Register Space Target

This block holds the 256-byte configuration register file of a single device function on a configuration bus. Each request carries a 24-bit address split into bus number, device/function number and register offset, a length code (1, 2 or 4 bytes), write data and a read/write flag. If the bus and device/function fields do not select this function, the block behaves as if no device is present: a read returns all ones at the requested width, and a write is dropped.

Writes are steered by a per-byte protection map chosen by the header type byte. A 4-byte write that lands in a base address register window with a non-zero implemented size takes a separate path. That path keeps only the size-aligned address bits and forces the type bits into the low end. For the expansion ROM register it keeps the enable bit instead. The current base address registers, the ROM register and the command register are driven out continuously for a downstream window decoder. A one-cycle pulse tells that decoder to re-evaluate its windows whenever the command register or a base register is written.

Top module: `cfg_space_target`

## Requirements
- R1: The address is decoded as bus = addr[23:16], devfn = addr[15:8], offset = addr[7:0]. The block responds only when bus equals BUS_NUM and devfn equals DEVFN.
- R2: A read to a non-matching bus or devfn returns 0xFF for length code 2'b00, 0xFFFF for 2'b01, and 0xFFFFFFFF for 2'b10 or 2'b11. A write to a non-matching target changes no register and raises no remap pulse.
- R3: Reads assemble bytes little-endian from the offset upward and zero the unused upper bytes. A 4-byte read is honoured up to offset 0xFC, and beyond that it becomes a 2-byte read. A 2-byte read is honoured up to offset 0xFE, and beyond that it becomes a 1-byte read.
- R4: Read data and rd_valid appear on the clock edge that samples the request. rd_valid is high for exactly that one cycle per read.
- R5: After reset the following reset values hold. Bytes 0x00–0x03 hold the vendor and device identifiers. Bytes 0x08–0x0B hold the revision and class code. Byte 0x0E holds the header type. Bytes 0x2C–0x2F hold the subsystem identifiers. Byte 0x3D holds the interrupt pin. Byte 0x10+4n holds the 4-bit type of base register n. All other bytes, the command register, rd_valid and remap are zero.
- R6: A 4-byte write at offsets 0x10–0x27 to base register n = (offset-0x10)/4 of non-zero size S stores (data & ~(S-1)) | type_n.
- R7: A 4-byte write at offsets 0x30–0x33 with a non-zero ROM size S stores (data & ~(S-1)) | (data & 1).
- R8: A 4-byte write to a base register of size zero takes the byte-wise path and is subject to the protection map.
- R9: With header type 0x00 or 0x80, byte writes to 0x00–0x03, 0x06–0x0B, 0x0E, 0x10–0x27, 0x2C–0x2F, 0x30–0x33 and 0x3D are ignored. Other bytes, including 0x38–0x3B, are writable.
- R10: With any other header type, 0x10–0x27 and 0x30–0x33 are writable byte-wise and 0x38–0x3B are read-only. The other read-only bytes of R9 stay read-only.
- R11: A write of 1, 2 or 4 bytes outside the base register path updates bytes from the offset upward and stops after offset 0xFF.
- R12: Bits [15:11] of the command register (offsets 0x04–0x05) are never set by a write.
- R13: remap is high for one cycle after an accepted write whose bytes overlap 0x04–0x05 or that took the base register path, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus [23:16], devfn [15:8], offset [7:0] |
| req_len | input | 2 | 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| req_wdata | input | 32 | Write data, byte 0 at the offset |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cmd_reg | output | 16 | Current command register |
| bar_regs | output | NUM_BARS*32 | Base registers, register 0 in the low word |
| rom_reg | output | 32 | Expansion ROM register |
| remap | output | 1 | Window re-evaluation pulse |

## Verification
The bench builds two instances on one request bus. The first uses header type 0x00 on bus 3. The second uses header type 0x01 on bus 5, so each instance serves as the absent target for the other's addresses. Both use devfn 0x28, a 256-byte prefetchable memory register 0 with type 0x8, a 32-byte I/O register 1 with type 0x1, unsized registers 2–5 and a 2 KB ROM. This setup exercises every masking form: the type-bit forcing, the ROM enable bit, and the byte-path fallback of an unsized register under both protection maps. Writes and reads around offset 0xFC–0xFF exercise the width fallback and the stop at the end of the space.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int NUM_BARS  = 6;
    localparam int CFG_BYTES = 256;
    localparam int BAR_W     = 32;
    localparam int TYPE_W    = 4;

    localparam logic [7:0] OFF_BAR_LO = 8'h10;
    localparam logic [7:0] OFF_BAR_HI = 8'h28;   // exclusive
    localparam logic [7:0] OFF_ROM_LO = 8'h30;
    localparam logic [7:0] OFF_ROM_HI = 8'h34;   // exclusive
    localparam logic [7:0] OFF_CMD    = 8'h04;
    localparam logic [7:0] OFF_HDR    = 8'h0E;

    typedef struct packed {
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        LEN_B1 = 2'b00,
        LEN_B2 = 2'b01,
        LEN_B4 = 2'b10
    } len_code_t;

    function automatic logic [2:0] len_bytes(input logic [1:0] code);
        case (code)
            LEN_B1:  return 3'd1;
            LEN_B2:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_type0(input logic [7:0] hdr);
        return (hdr == 8'h00) || (hdr == 8'h80);
    endfunction

    // Per-byte write protection chosen by header type.
    function automatic logic byte_locked(input logic [7:0] off, input logic [7:0] hdr);
        logic common;
        common = (off <= 8'h03) ||
                 (off >= 8'h06 && off <= 8'h0B) ||
                 (off == OFF_HDR) ||
                 (off >= 8'h2C && off <= 8'h2F) ||
                 (off == 8'h3D);
        if (is_type0(hdr))
            return common ||
                   (off >= OFF_BAR_LO && off < OFF_BAR_HI) ||
                   (off >= OFF_ROM_LO && off < OFF_ROM_HI);
        return common || (off >= 8'h38 && off <= 8'h3B);
    endfunction

    // Reserved-bit keep mask: command high byte keeps bits [10:8] only.
    function automatic logic [7:0] byte_keep(input logic [7:0] off);
        return (off == 8'h05) ? 8'h07 : 8'hFF;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_space_pkg::*;
#(
    parameter logic [7:0] BUS_NUM = 8'h00,
    parameter logic [7:0] DEVFN   = 8'h00
) (
    input  logic [23:0] addr,
    input  logic [1:0]  len,
    output logic        hit,
    output logic [7:0]  off,
    output logic [2:0]  req_nbytes,
    output logic [2:0]  rd_nbytes,
    output logic [31:0] absent_fill
);
    cfg_addr_t fields;

    always_comb begin
        fields     = cfg_addr_t'(addr);
        hit        = (fields.bus == BUS_NUM) && (fields.devfn == DEVFN);
        off        = fields.off;
        req_nbytes = len_bytes(len);

        rd_nbytes = req_nbytes;
        if (rd_nbytes == 3'd4 && off > 8'hFC) rd_nbytes = 3'd2;
        if (rd_nbytes == 3'd2 && off > 8'hFE) rd_nbytes = 3'd1;

        case (req_nbytes)
            3'd1:    absent_fill = 32'h0000_00FF;
            3'd2:    absent_fill = 32'h0000_FFFF;
            default: absent_fill = 32'hFFFF_FFFF;
        endcase
    end
endmodule

// File: rtl/cfg_write_lanes.sv
module cfg_write_lanes
    import cfg_space_pkg::*;
#(
    parameter logic [NUM_BARS*BAR_W-1:0]  BAR_SIZE = '0,
    parameter logic [NUM_BARS*TYPE_W-1:0] BAR_TYPE = '0,
    parameter logic [31:0]                ROM_SIZE = 32'h0
) (
    input  logic        en,
    input  logic [7:0]  off,
    input  logic [2:0]  nbytes,
    input  logic [31:0] wdata,
    input  logic [7:0]  hdr,
    output logic        bar_path,
    output logic [3:0]  lane_we,
    output logic [31:0] lane_data
);
    logic [31:0] size_tab [NUM_BARS];
    logic [31:0] type_tab [NUM_BARS];
    logic        in_std, in_rom;
    logic [2:0]  idx;
    logic [7:0]  rel;
    logic [31:0] size, keep, bar_val;

    always_comb begin
        for (int b = 0; b < NUM_BARS; b++) begin
            size_tab[b] = BAR_SIZE[b*BAR_W +: BAR_W];
            type_tab[b] = {28'h0, BAR_TYPE[b*TYPE_W +: TYPE_W]};
        end
        in_std = (nbytes == 3'd4) && (off >= OFF_BAR_LO) && (off < OFF_BAR_HI);
        in_rom = (nbytes == 3'd4) && (off >= OFF_ROM_LO) && (off < OFF_ROM_HI);
        rel    = off - OFF_BAR_LO;
        idx    = in_std ? rel[4:2] : 3'd0;
        size   = in_rom ? ROM_SIZE : size_tab[idx];
        keep   = ~(size - 32'd1);
        bar_path = (in_std || in_rom) && (size != 32'd0);
        bar_val  = in_rom ? ((wdata & keep) | (wdata & 32'h1))
                          : ((wdata & keep) | type_tab[idx]);
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [8:0] baddr;
        logic       in_span;
        always_comb begin
            baddr   = {1'b0, off} + 9'(k);
            in_span = (3'(k) < nbytes) && (baddr <= 9'h0FF);
            lane_we[k] = en && in_span && (bar_path || !byte_locked(baddr[7:0], hdr));
            lane_data[8*k +: 8] = bar_path ? bar_val[8*k +: 8]
                                           : (wdata[8*k +: 8] & byte_keep(baddr[7:0]));
        end
    end
endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
    import cfg_space_pkg::*;
#(
    parameter logic [7:0]                 BUS_NUM       = 8'h00,
    parameter logic [7:0]                 DEVFN         = 8'h00,
    parameter logic [15:0]                VENDOR_ID     = 16'hFFFF,
    parameter logic [15:0]                DEVICE_ID     = 16'hFFFF,
    parameter logic [7:0]                 REVISION      = 8'h00,
    parameter logic [23:0]                CLASS_CODE    = 24'h000000,
    parameter logic [15:0]                SUBSYS_VENDOR = 16'h0000,
    parameter logic [15:0]                SUBSYS_ID     = 16'h0000,
    parameter logic [7:0]                 INT_PIN       = 8'h00,
    parameter logic [7:0]                 HEADER_TYPE   = 8'h00,
    parameter logic [NUM_BARS*BAR_W-1:0]  BAR_SIZE      = '0,
    parameter logic [NUM_BARS*TYPE_W-1:0] BAR_TYPE      = '0,
    parameter logic [31:0]                ROM_SIZE      = 32'h0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [23:0]               req_addr,
    input  logic [1:0]                req_len,
    input  logic [31:0]               req_wdata,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    output logic [15:0]               cmd_reg,
    output logic [NUM_BARS*BAR_W-1:0] bar_regs,
    output logic [31:0]               rom_reg,
    output logic                      remap
);
    logic [7:0]  cfg_q [CFG_BYTES];
    logic        hit, bar_path, cmd_touch;
    logic [7:0]  off;
    logic [2:0]  req_nbytes, rd_nbytes;
    logic [31:0] absent_fill, lane_data, gather;
    logic [3:0]  lane_we;
    logic [8:0]  end_off;

    function automatic logic [7:0] reset_byte(input int i);
        logic [7:0] v;
        v = 8'h00;
        case (i)
            0: v = VENDOR_ID[7:0];
            1: v = VENDOR_ID[15:8];
            2: v = DEVICE_ID[7:0];
            3: v = DEVICE_ID[15:8];
            8: v = REVISION;
            9: v = CLASS_CODE[7:0];
            10: v = CLASS_CODE[15:8];
            11: v = CLASS_CODE[23:16];
            14: v = HEADER_TYPE;
            44: v = SUBSYS_VENDOR[7:0];
            45: v = SUBSYS_VENDOR[15:8];
            46: v = SUBSYS_ID[7:0];
            47: v = SUBSYS_ID[15:8];
            61: v = INT_PIN;
            default: begin
                if (i >= 16 && i < 16 + 4*NUM_BARS && (i % 4) == 0)
                    v = {4'h0, BAR_TYPE[((i-16)/4)*TYPE_W +: TYPE_W]};
            end
        endcase
        return v;
    endfunction

    cfg_addr_decode #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_dec (
        .addr(req_addr), .len(req_len), .hit(hit), .off(off),
        .req_nbytes(req_nbytes), .rd_nbytes(rd_nbytes), .absent_fill(absent_fill)
    );

    cfg_write_lanes #(.BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .ROM_SIZE(ROM_SIZE)) u_wr (
        .en(req_valid && req_write && hit), .off(off), .nbytes(req_nbytes),
        .wdata(req_wdata), .hdr(cfg_q[OFF_HDR]), .bar_path(bar_path),
        .lane_we(lane_we), .lane_data(lane_data)
    );

    always_comb begin
        gather = '0;
        for (int k = 0; k < 4; k++)
            if (3'(k) < rd_nbytes)
                gather[8*k +: 8] = cfg_q[off + 8'(k)];
        end_off   = {1'b0, off} + {6'h0, req_nbytes};
        cmd_touch = (off <= OFF_CMD + 8'd1) && (end_off > {1'b0, OFF_CMD});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++) cfg_q[i] <= reset_byte(i);
            rd_valid <= 1'b0;
            rd_data  <= '0;
            remap    <= 1'b0;
        end else begin
            for (int k = 0; k < 4; k++)
                if (lane_we[k]) cfg_q[off + 8'(k)] <= lane_data[8*k +: 8];
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rd_data <= hit ? gather : absent_fill;
            remap <= req_valid && req_write && hit && (bar_path || cmd_touch);
        end
    end

    assign cmd_reg = {cfg_q[OFF_CMD + 8'd1], cfg_q[OFF_CMD]};
    assign rom_reg = {cfg_q[8'h33], cfg_q[8'h32], cfg_q[8'h31], cfg_q[8'h30]};

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        localparam logic [7:0]  BOFF  = OFF_BAR_LO + 8'(4*b);
        localparam logic [31:0] BSIZE = BAR_SIZE[b*BAR_W +: BAR_W];
        localparam logic [31:0] BTYPE = {28'h0, BAR_TYPE[b*TYPE_W +: TYPE_W]};
        assign bar_regs[b*BAR_W +: BAR_W] =
            {cfg_q[BOFF + 8'd3], cfg_q[BOFF + 8'd2], cfg_q[BOFF + 8'd1], cfg_q[BOFF]};
        if (BSIZE != 32'd0 && is_type0(HEADER_TYPE)) begin : g_chk
            assert_bar_align_R6: assert property (@(posedge clk) disable iff (rst)
                ((bar_regs[b*BAR_W +: BAR_W] & (BSIZE - 32'd1)) == (BTYPE & (BSIZE - 32'd1))));
        end
    end

    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);
    assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);
    assert_absent_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !hit) |=>
        (rd_data == (($past(req_len) == 2'b00) ? 32'h0000_00FF :
                     ($past(req_len) == 2'b01) ? 32'h0000_FFFF : 32'hFFFF_FFFF)));
    assert_absent_noremap_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit) |=> !remap);
    assert_ids_fixed_R9: assert property (@(posedge clk) disable iff (rst)
        $stable({cfg_q[0], cfg_q[1], cfg_q[2], cfg_q[3], cfg_q[OFF_HDR]}));
    assert_cmd_reserved_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_reg[15:11] == 5'b0);
    assert_cmd_remap_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && hit && off == OFF_CMD) |=> remap);
endmodule

// File: tb/tb_cfg_space_target.sv
module tb_cfg_space_target;
    import cfg_space_pkg::*;

    localparam logic [NUM_BARS*BAR_W-1:0] SIZES =
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h100};
    localparam logic [NUM_BARS*TYPE_W-1:0] TYPES =
        {4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid_a, rd_valid_b, remap_a, remap_b;
    logic [31:0] rd_data_a, rd_data_b, rom_a, rom_b;
    logic [15:0] cmd_a, cmd_b;
    logic [NUM_BARS*BAR_W-1:0] bars_a, bars_b;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_space_target #(
        .BUS_NUM(8'h03), .DEVFN(8'h28), .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h5A17),
        .REVISION(8'h03), .CLASS_CODE(24'h020000), .SUBSYS_VENDOR(16'hBEEF),
        .SUBSYS_ID(16'h0042), .INT_PIN(8'h01), .HEADER_TYPE(8'h00),
        .BAR_SIZE(SIZES), .BAR_TYPE(TYPES), .ROM_SIZE(32'h800)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rd_valid(rd_valid_a), .rd_data(rd_data_a), .cmd_reg(cmd_a),
        .bar_regs(bars_a), .rom_reg(rom_a), .remap(remap_a)
    );

    cfg_space_target #(
        .BUS_NUM(8'h05), .DEVFN(8'h28), .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h5A17),
        .REVISION(8'h03), .CLASS_CODE(24'h060400), .SUBSYS_VENDOR(16'hBEEF),
        .SUBSYS_ID(16'h0042), .INT_PIN(8'h01), .HEADER_TYPE(8'h01),
        .BAR_SIZE(SIZES), .BAR_TYPE(TYPES), .ROM_SIZE(32'h800)
    ) dut_b (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rd_valid(rd_valid_b), .rd_data(rd_data_b), .cmd_reg(cmd_b),
        .bar_regs(bars_b), .rom_reg(rom_b), .remap(remap_b)
    );

    // {req tag, write, len, addr, wdata, expected read}
    localparam int NV = 35;
    localparam logic [94:0] VEC [NV] = '{
        {4'd5,  1'b0, 2'd2, 24'h032800, 32'h0, 32'h5A17C0DE},  // R5 ids
        {4'd3,  1'b0, 2'd1, 24'h032802, 32'h0, 32'h00005A17},  // R3 half
        {4'd5,  1'b0, 2'd0, 24'h03280B, 32'h0, 32'h00000002},  // R5 class
        {4'd5,  1'b0, 2'd2, 24'h03282C, 32'h0, 32'h0042BEEF},  // R5 subsystem
        {4'd5,  1'b0, 2'd2, 24'h032810, 32'h0, 32'h00000008},  // R5 bar type
        {4'd6,  1'b1, 2'd2, 24'h032810, 32'hFFFFFFFF, 32'h0},
        {4'd6,  1'b0, 2'd2, 24'h032810, 32'h0, 32'hFFFFFF08},  // R6 memory
        {4'd6,  1'b1, 2'd2, 24'h032814, 32'h12345677, 32'h0},
        {4'd6,  1'b0, 2'd2, 24'h032814, 32'h0, 32'h12345661},  // R6 io
        {4'd7,  1'b1, 2'd2, 24'h032830, 32'hFFFFFFFF, 32'h0},
        {4'd7,  1'b0, 2'd2, 24'h032830, 32'h0, 32'hFFFFF801},  // R7 enable kept
        {4'd7,  1'b1, 2'd2, 24'h032830, 32'h0000ABCE, 32'h0},
        {4'd7,  1'b0, 2'd2, 24'h032830, 32'h0, 32'h0000A800},  // R7 enable clear
        {4'd8,  1'b1, 2'd2, 24'h032818, 32'h11223344, 32'h0},
        {4'd8,  1'b0, 2'd2, 24'h032818, 32'h0, 32'h00000000},  // R8 unsized
        {4'd9,  1'b1, 2'd2, 24'h032800, 32'h00000000, 32'h0},
        {4'd9,  1'b0, 2'd2, 24'h032800, 32'h0, 32'h5A17C0DE},  // R9 ids locked
        {4'd12, 1'b1, 2'd1, 24'h032804, 32'h0000FFFF, 32'h0},
        {4'd12, 1'b0, 2'd1, 24'h032804, 32'h0, 32'h000007FF},  // R12 reserved
        {4'd9,  1'b1, 2'd2, 24'h03283C, 32'hAABBCCDD, 32'h0},
        {4'd9,  1'b0, 2'd2, 24'h03283C, 32'h0, 32'hAABB01DD},  // R9 pin locked
        {4'd9,  1'b1, 2'd0, 24'h032838, 32'h0000005A, 32'h0},
        {4'd9,  1'b0, 2'd0, 24'h032838, 32'h0, 32'h0000005A},  // R9 0x38 open
        {4'd11, 1'b1, 2'd2, 24'h0328FE, 32'h00001234, 32'h0},
        {4'd11, 1'b0, 2'd2, 24'h0328FC, 32'h0, 32'h12340000},  // R11 stop at end
        {4'd3,  1'b0, 2'd2, 24'h0328FD, 32'h0, 32'h00003400},  // R3 word->half
        {4'd3,  1'b0, 2'd2, 24'h0328FF, 32'h0, 32'h00000012},  // R3 word->byte
        {4'd3,  1'b0, 2'd1, 24'h0328FF, 32'h0, 32'h00000012},  // R3 half->byte
        {4'd2,  1'b0, 2'd0, 24'h042800, 32'h0, 32'h000000FF},  // R2 R1 bus
        {4'd2,  1'b0, 2'd1, 24'h032900, 32'h0, 32'h0000FFFF},  // R2 R1 devfn
        {4'd2,  1'b0, 2'd3, 24'h032900, 32'h0, 32'hFFFFFFFF},  // R2 code 11
        {4'd2,  1'b1, 2'd2, 24'h03293C, 32'h00000000, 32'h0},
        {4'd2,  1'b0, 2'd2, 24'h03283C, 32'h0, 32'hAABB01DD},  // R2 write dropped
        {4'd9,  1'b1, 2'd0, 24'h03280E, 32'h00000001, 32'h0},
        {4'd9,  1'b0, 2'd0, 24'h03280E, 32'h0, 32'h00000000}   // R9 header locked
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] l,
                          input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_len = l; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check("R5 rd_valid", {31'h0, rd_valid_a}, 32'h0);
        check("R5 remap", {31'h0, remap_a}, 32'h0);
        check("R5 cmd", {16'h0, cmd_a}, 32'h0);
        check("R5 bar1", bars_a[63:32], 32'h00000001);
        check("R5 rom", rom_a, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [94:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[94:91], i);
            access(v[90], v[89:88], v[87:64], v[63:32]);
            if (!v[90]) begin
                check({tag, " valid"}, {31'h0, rd_valid_a}, 32'h1);
                check(tag, rd_data_a, v[31:0]);
            end
        end

        // R4 single-cycle valid
        @(negedge clk);
        check("R4 valid drops", {31'h0, rd_valid_a}, 32'h0);

        // R13 remap pulses
        access(1'b1, 2'd0, 24'h032804, 32'h02);
        check("R13 cmd write", {31'h0, remap_a}, 32'h1);
        check("R12 cmd value", {16'h0, cmd_a}, 32'h00000702);
        @(negedge clk);
        check("R13 one cycle", {31'h0, remap_a}, 32'h0);
        access(1'b1, 2'd0, 24'h032806, 32'hFF);
        check("R13 no cmd overlap", {31'h0, remap_a}, 32'h0);
        access(1'b1, 2'd2, 24'h032814, 32'h00000000);
        check("R13 bar write", {31'h0, remap_a}, 32'h1);
        check("R6 bar1 port", bars_a[63:32], 32'h00000001);
        access(1'b1, 2'd1, 24'h032904, 32'hFFFF);
        check("R2 absent remap", {31'h0, remap_a}, 32'h0);

        // R10 other header type on bus 5
        access(1'b1, 2'd0, 24'h052810, 32'h77);
        access(1'b0, 2'd0, 24'h052810, 32'h0);
        check("R10 bar byte writable", rd_data_b, 32'h00000077);
        check("R1 other bus ignored", rd_data_a, 32'h000000FF);
        access(1'b1, 2'd0, 24'h052838, 32'h55);
        access(1'b0, 2'd0, 24'h052838, 32'h0);
        check("R10 0x38 locked", rd_data_b, 32'h00000000);
        access(1'b1, 2'd2, 24'h052818, 32'h11223344);
        access(1'b0, 2'd2, 24'h052818, 32'h0);
        check("R10 R8 unsized writable", rd_data_b, 32'h11223344);
        access(1'b1, 2'd2, 24'h052810, 32'hFFFFFFFF);
        check("R13 bar remap b", {31'h0, remap_b}, 32'h1);
        check("R6 bar0 b", bars_b[31:0], 32'hFFFFFF08);
        access(1'b1, 2'd0, 24'h052800, 32'h00);
        access(1'b0, 2'd2, 24'h052800, 32'h0);
        check("R10 ids locked", rd_data_b, 32'h5A17C0DE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule